// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the register side of taking a processor exception. When the pipeline raises a request, the block records the faulting program counter, the cause and, optionally, the faulting virtual address. It updates the processor-state word (PS) that it owns and picks one of four dispatch vectors, which it drives as a one-hot select. All of this happens in a single clock. General exceptions use an "exception in progress" flag in PS. A second exception that arrives while that flag is set becomes a double exception. The double exception saves its PC either into a dedicated double-exception PC register or, when that register is not configured, into the first-level exception PC.

Debug exceptions take a separate path that is based on interrupt level. They are taken only when the current interrupt level is below the configured debug level. A taken debug exception saves the PC and the old PS into that level's registers, raises the interrupt level to the debug level and sets the in-progress flag. A debug exception that is not taken leaves every register unchanged. The core can also load PS directly, for example when it returns from a handler.

The vector state machine has five states. IDLE_NONE holds after reset. DISP_KERNEL, DISP_USER, DISP_DOUBLE and DISP_DEBUG each hold the last vector dispatched. These are the transitions:
- GEN_TAKE: a general request moves the machine to DISP_DOUBLE if the in-progress flag is set. Otherwise it moves to DISP_USER when PS.um is set, or to DISP_KERNEL when it is clear.
- DBG_TAKE: a debug request that is taken moves the machine to DISP_DEBUG.
- HOLD: no request, or a debug request that is dropped, keeps the machine in its current state.

Top module: `exc_entry_seq`

PS layout: bits [2:0] hold the interrupt level, bit 3 is excm (exception in progress), bit 4 is um (user mode), and bits [7:5] are spare. Vector encoding: bit 0 is kernel, bit 1 is user, bit 2 is double, bit 3 is debug, and all zero means none.

## Requirements
- R1: A general request that arrives while PS bit 3 is set drives vector bit 2. If the dedicated double PC is configured, the PC goes to `depc` and `epc1` is unchanged. If it is not configured, the PC goes to `epc1`.
- R2: A general request that arrives while PS bit 3 is clear writes the PC to `epc1`. It drives vector bit 1 when PS bit 4 is set and vector bit 0 when PS bit 4 is clear.
- R3: Every general request writes its cause to `exc_cause` and sets PS bit 3. All other PS bits keep their old values.
- R4: A general request with `req_has_addr` high writes `req_addr` to `exc_vaddr`. A request without it leaves `exc_vaddr` unchanged.
- R5: A debug request taken at level L (parameter `DBG_LEVEL`, 2 to 7) does the following. It writes the PC to `epc_dbg`, the old PS to `eps_dbg` and the cause to `dbg_cause`. It sets PS[2:0] to L, sets PS bit 3 and drives vector bit 3. It leaves `epc1`, `exc_cause` and `exc_vaddr` unchanged.
- R6: A debug request is dropped when PS[2:0] is at least L. A dropped request changes no output.
- R7: Every update commits on the clock edge that samples `req_valid`. The vector is held until the next request that is taken.
- R8: Reset clears PS, including excm and um. It sets the vector to none and clears all saved registers.
- R9: `ps_load` writes `ps_load_val` into PS when no request is present. It is ignored in a cycle that also carries a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Exception request strobe |
| req_debug | input | 1 | 1 selects a debug request, 0 a general one |
| req_has_addr | input | 1 | The request carries a faulting address |
| req_cause | input | CAUSE_W | Cause code |
| req_pc | input | XLEN | Faulting PC |
| req_addr | input | XLEN | Faulting virtual address |
| ps_load | input | 1 | Direct PS load strobe |
| ps_load_val | input | 8 | Value for the PS load |
| ps_out | output | 8 | Current PS |
| vec_sel | output | 4 | One-hot dispatch vector |
| epc1 | output | XLEN | First-level exception PC |
| depc | output | XLEN | Double-exception PC (zero when not configured) |
| epc_dbg | output | XLEN | Saved PC at the debug level |
| eps_dbg | output | 8 | Saved PS at the debug level |
| exc_cause | output | CAUSE_W | Cause of the last general exception |
| exc_vaddr | output | XLEN | Last faulting virtual address |
| dbg_cause | output | CAUSE_W | Cause of the last debug exception |

## Verification
Every one of the 256 PS values is loaded, and each is followed by three kinds of request: general without an address, general with an address, and debug. The sweep therefore covers every combination of excm and um, which separates the kernel, user and double vectors. It also covers every interrupt level on both sides of the debug threshold, which separates a taken debug exception from a dropped one. Two instances run the sweep side by side, one with the double PC configured and one without, so the sweep shows where the PC lands in each case. Directed steps cover a PS load in the same cycle as a request, and confirm that the vector is held through idle cycles.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int PS_W     = 8;
    localparam int IL_W     = 3;
    localparam int EXCM_BIT = 3;
    localparam int UM_BIT   = 4;
    localparam int VEC_W    = 4;

    typedef enum logic [2:0] {
        IDLE_NONE   = 3'd0,
        DISP_KERNEL = 3'd1,
        DISP_USER   = 3'd2,
        DISP_DOUBLE = 3'd3,
        DISP_DEBUG  = 3'd4
    } vec_state_e;
endpackage

// File: rtl/exc_route.sv
module exc_route
    import exc_pkg::*;
#(
    parameter int DBG_LEVEL = 3
) (
    input  logic             req_valid,
    input  logic             req_debug,
    input  logic [PS_W-1:0]  ps_cur,
    input  vec_state_e       state_cur,
    output logic             take_gen,
    output logic             take_dbg,
    output logic [PS_W-1:0]  ps_next,
    output vec_state_e       state_next
);
    localparam logic [IL_W-1:0] LVL = IL_W'(DBG_LEVEL);

    logic dbg_allowed;
    assign dbg_allowed = ps_cur[IL_W-1:0] < LVL;
    assign take_gen    = req_valid && !req_debug;
    assign take_dbg    = req_valid && req_debug && dbg_allowed;

    always_comb begin
        ps_next    = ps_cur;
        state_next = state_cur;
        if (take_gen) begin
            ps_next[EXCM_BIT] = 1'b1;
            if (ps_cur[EXCM_BIT])    state_next = DISP_DOUBLE;
            else if (ps_cur[UM_BIT]) state_next = DISP_USER;
            else                     state_next = DISP_KERNEL;
        end else if (take_dbg) begin
            ps_next[IL_W-1:0] = LVL;
            ps_next[EXCM_BIT] = 1'b1;
            state_next        = DISP_DEBUG;
        end
    end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
    import exc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6,
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_gen,
    input  logic               take_dbg,
    input  logic               excm_before,
    input  logic               has_addr,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    addr,
    input  logic [PS_W-1:0]    ps_old,
    output logic [XLEN-1:0]    epc1,
    output logic [XLEN-1:0]    depc,
    output logic [XLEN-1:0]    epc_dbg,
    output logic [PS_W-1:0]    eps_dbg,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN-1:0]    exc_vaddr,
    output logic [CAUSE_W-1:0] dbg_cause
);
    logic wr_epc1;
    assign wr_epc1 = take_gen && (!excm_before || !HAS_DEPC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc1      <= '0;
            exc_cause <= '0;
            exc_vaddr <= '0;
        end else begin
            if (wr_epc1)              epc1      <= pc;
            if (take_gen)             exc_cause <= cause;
            if (take_gen && has_addr) exc_vaddr <= addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_dbg   <= '0;
            eps_dbg   <= '0;
            dbg_cause <= '0;
        end else if (take_dbg) begin
            epc_dbg   <= pc;
            eps_dbg   <= ps_old;
            dbg_cause <= cause;
        end
    end

    generate
        if (HAS_DEPC) begin : g_depc
            logic [XLEN-1:0] depc_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       depc_q <= '0;
                else if (take_gen && excm_before) depc_q <= pc;
            end
            assign depc = depc_q;
        end else begin : g_no_depc
            assign depc = '0;
        end
    endgenerate
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int CAUSE_W   = 6,
    parameter int DBG_LEVEL = 3,
    parameter bit HAS_DEPC  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_debug,
    input  logic               req_has_addr,
    input  logic [CAUSE_W-1:0] req_cause,
    input  logic [XLEN-1:0]    req_pc,
    input  logic [XLEN-1:0]    req_addr,
    input  logic               ps_load,
    input  logic [7:0]         ps_load_val,
    output logic [7:0]         ps_out,
    output logic [3:0]         vec_sel,
    output logic [XLEN-1:0]    epc1,
    output logic [XLEN-1:0]    depc,
    output logic [XLEN-1:0]    epc_dbg,
    output logic [7:0]         eps_dbg,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN-1:0]    exc_vaddr,
    output logic [CAUSE_W-1:0] dbg_cause
);
    vec_state_e        state_q, state_d;
    logic [PS_W-1:0]   ps_q, ps_d;
    logic              take_gen, take_dbg;

    exc_route #(.DBG_LEVEL(DBG_LEVEL)) u_route (
        .req_valid  (req_valid),
        .req_debug  (req_debug),
        .ps_cur     (ps_q),
        .state_cur  (state_q),
        .take_gen   (take_gen),
        .take_dbg   (take_dbg),
        .ps_next    (ps_d),
        .state_next (state_d)
    );

    exc_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_DEPC(HAS_DEPC)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_gen    (take_gen),
        .take_dbg    (take_dbg),
        .excm_before (ps_q[EXCM_BIT]),
        .has_addr    (req_has_addr),
        .cause       (req_cause),
        .pc          (req_pc),
        .addr        (req_addr),
        .ps_old      (ps_q),
        .epc1        (epc1),
        .depc        (depc),
        .epc_dbg     (epc_dbg),
        .eps_dbg     (eps_dbg),
        .exc_cause   (exc_cause),
        .exc_vaddr   (exc_vaddr),
        .dbg_cause   (dbg_cause)
    );

    // State and PS register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDLE_NONE;
            ps_q    <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid)    ps_q <= ps_d;
            else if (ps_load) ps_q <= ps_load_val;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            IDLE_NONE:   vec_sel = 4'b0000;
            DISP_KERNEL: vec_sel = 4'b0001;
            DISP_USER:   vec_sel = 4'b0010;
            DISP_DOUBLE: vec_sel = 4'b0100;
            DISP_DEBUG:  vec_sel = 4'b1000;
            default:     vec_sel = 4'b0000;
        endcase
    end
    assign ps_out = ps_q;

    assert_vec_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_sel));
    assert_double_vec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_debug && ps_out[EXCM_BIT]) |=> (vec_sel == 4'b0100));
    assert_excm_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_debug) |=> ps_out[EXCM_BIT]);
    assert_dbg_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_debug && (ps_out[2:0] < 3'(DBG_LEVEL)))
        |=> (ps_out[2:0] == 3'(DBG_LEVEL)) && vec_sel[3]);
    assert_dbg_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_debug && (ps_out[2:0] >= 3'(DBG_LEVEL)))
        |=> $stable(ps_out) && $stable(vec_sel) && $stable(epc_dbg));
    assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(vec_sel));
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
    localparam int L = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_debug = 0, req_has_addr = 0, ps_load = 0;
    logic [5:0]  req_cause = '0;
    logic [31:0] req_pc = '0, req_addr = '0;
    logic [7:0]  ps_load_val = '0;

    logic [7:0]  ps_a, ps_b, eps_a, eps_b;
    logic [3:0]  vec_a, vec_b;
    logic [31:0] epc1_a, epc1_b, depc_a, depc_b, epcd_a, epcd_b, va_a, va_b;
    logic [5:0]  ca_a, ca_b, dc_a, dc_b;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0]  m_ps, m_eps;
    logic [3:0]  m_vec;
    logic [31:0] m_epc1_a, m_epc1_b, m_depc, m_epcd, m_vaddr;
    logic [5:0]  m_cause, m_dcause;

    always #10 clk = ~clk;

    exc_entry_seq #(.XLEN(32), .CAUSE_W(6), .DBG_LEVEL(L), .HAS_DEPC(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_debug(req_debug),
        .req_has_addr(req_has_addr), .req_cause(req_cause), .req_pc(req_pc),
        .req_addr(req_addr), .ps_load(ps_load), .ps_load_val(ps_load_val),
        .ps_out(ps_a), .vec_sel(vec_a), .epc1(epc1_a), .depc(depc_a),
        .epc_dbg(epcd_a), .eps_dbg(eps_a), .exc_cause(ca_a), .exc_vaddr(va_a),
        .dbg_cause(dc_a));

    exc_entry_seq #(.XLEN(32), .CAUSE_W(6), .DBG_LEVEL(L), .HAS_DEPC(1'b0)) dut_b (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_debug(req_debug),
        .req_has_addr(req_has_addr), .req_cause(req_cause), .req_pc(req_pc),
        .req_addr(req_addr), .ps_load(ps_load), .ps_load_val(ps_load_val),
        .ps_out(ps_b), .vec_sel(vec_b), .epc1(epc1_b), .depc(depc_b),
        .epc_dbg(epcd_b), .eps_dbg(eps_b), .exc_cause(ca_b), .exc_vaddr(va_b),
        .dbg_cause(dc_b));

    task automatic chk(input string tag, input string name,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, name, got, exp);
        end
    endtask

    task automatic check_all(input string t_vec, input string t_ps, input string t_reg);
        chk(t_vec, "vec_a",   32'(vec_a),  32'(m_vec));
        chk(t_vec, "vec_b",   32'(vec_b),  32'(m_vec));
        chk(t_ps,  "ps_a",    32'(ps_a),   32'(m_ps));
        chk(t_ps,  "ps_b",    32'(ps_b),   32'(m_ps));
        chk(t_reg, "epc1_a",  epc1_a,      m_epc1_a);
        chk(t_reg, "epc1_b",  epc1_b,      m_epc1_b);
        chk(t_reg, "depc_a",  depc_a,      m_depc);
        chk(t_reg, "depc_b",  depc_b,      32'h0);
        chk(t_reg, "cause",   32'(ca_a),   32'(m_cause));
        chk(t_reg, "cause_b", 32'(ca_b),   32'(m_cause));
        chk(t_reg, "vaddr",   va_a,        m_vaddr);
        chk(t_reg, "vaddr_b", va_b,        m_vaddr);
        chk(t_reg, "epc_dbg", epcd_a,      m_epcd);
        chk(t_reg, "epcd_b",  epcd_b,      m_epcd);
        chk(t_reg, "eps_dbg", 32'(eps_a),  32'(m_eps));
        chk(t_reg, "eps_b",   32'(eps_b),  32'(m_eps));
        chk(t_reg, "dcause",  32'(dc_a),   32'(m_dcause));
        chk(t_reg, "dcause_b",32'(dc_b),   32'(m_dcause));
    endtask

    task automatic model_req(input int kind, input logic [5:0] c,
                             input logic [31:0] pc, input logic [31:0] ad);
        if (kind < 2) begin
            if (kind == 1) m_vaddr = ad;
            if (m_ps[3]) begin
                m_vec = 4'b0100; m_depc = pc; m_epc1_b = pc;
            end else begin
                m_vec = m_ps[4] ? 4'b0010 : 4'b0001;
                m_epc1_a = pc; m_epc1_b = pc;
            end
            m_cause = c;
            m_ps = m_ps | 8'h08;
        end else if (m_ps[2:0] < 3'(L)) begin
            m_epcd = pc; m_eps = m_ps; m_dcause = c; m_vec = 4'b1000;
            m_ps = (m_ps & 8'hF8) | 8'(L) | 8'h08;
        end
    endtask

    task automatic do_req(input int kind, input logic [5:0] c,
                          input logic [31:0] pc, input logic [31:0] ad, input bit with_load);
        string tv, tp, tr;
        bit dropped;
        dropped = (kind == 2) && (m_ps[2:0] >= 3'(L));
        req_valid = 1; req_debug = (kind == 2); req_has_addr = (kind == 1);
        req_cause = c; req_pc = pc; req_addr = ad;
        ps_load = with_load; ps_load_val = 8'hE0;
        @(negedge clk);
        req_valid = 0; req_has_addr = 0; ps_load = 0;
        if (kind < 2) model_req(kind, c, pc, ad);
        else          model_req(kind, c, pc, ad);
        if (dropped)        begin tv = "R6"; tp = "R6"; tr = "R6"; end
        else if (kind == 2) begin tv = "R5"; tp = "R5"; tr = "R5"; end
        else begin
            tv = (m_vec == 4'b0100) ? "R1" : "R2";
            tp = with_load ? "R9" : "R3";
            tr = (kind == 1) ? "R4" : "R3";
        end
        check_all(tv, tp, tr);
    endtask

    task automatic load_ps(input logic [7:0] v);
        ps_load = 1; ps_load_val = v;
        @(negedge clk);
        ps_load = 0;
        m_ps = v;
        chk("R9", "ps_load_a", 32'(ps_a), 32'(v));
        chk("R9", "ps_load_b", 32'(ps_b), 32'(v));
    endtask

    initial begin
        m_ps = 0; m_eps = 0; m_vec = 0; m_epc1_a = 0; m_epc1_b = 0; m_depc = 0;
        m_epcd = 0; m_vaddr = 0; m_cause = 0; m_dcause = 0;
        repeat (3) @(negedge clk);
        check_all("R8", "R8", "R8");
        rst_n = 1;
        @(negedge clk);
        check_all("R8", "R8", "R8");

        for (int p = 0; p < 256; p++) begin
            for (int k = 0; k < 3; k++) begin
                load_ps(8'(p));
                do_req(k, 6'(p ^ (k * 21)), {8'hC0, 8'(k), 8'(p), 8'h5A},
                       {8'h3E, 8'(p), 8'(k), 8'h01}, 1'b0);
            end
        end

        // R9: PS load in the same cycle as a request is ignored
        load_ps(8'h00);
        do_req(0, 6'h11, 32'h1000_0040, 32'h0, 1'b1);
        load_ps(8'h10);
        do_req(1, 6'h22, 32'h2000_0080, 32'hDEAD_BEEF, 1'b1);

        // R7: vector held through idle cycles
        repeat (4) @(negedge clk);
        check_all("R7", "R7", "R7");
        load_ps(8'h00);
        chk("R7", "vec_after_load", 32'(vec_a), 32'(m_vec));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule